// File: doc/BRIEF.md
# Dual-View GPIO Controller with Pin Ownership

This block controls 24 general purpose pins. Each pin has one set of state: output value, drive direction, interrupt level, interrupt flag and interrupt mask. Two register windows on a single 32-bit bus reach that state. The privileged window reaches every pin. The secondary window reaches only the pins that the privileged side has handed over through an owner mask. Both windows read and write the same stored bits. Handing a pin to the other side therefore moves no data; it only changes which window sees the pin.

Pin inputs pass through a two-flop synchroniser. The synchronised value feeds the input register and the interrupt logic. A flag bit is raised on every cycle in which its pin sits at the level chosen for it. Software clears a flag by writing a 1 to it.

There are two interrupt lines. Each pin feeds exactly one of them, chosen by its owner bit. A read-only register keeps the pin values that were captured once, shortly after reset.

Top module: `gpio_dual_view`

## Requirements
- R1: After reset, the enable, output, direction, level, mask and owner registers all read 0, and no pin is driven (pin_oe = 0).
- R2: The privileged window decodes these byte offsets: 0x1C enable, 0x20 output, 0x24 direction, 0x28 input, 0x2C level, 0x30 flag, 0x34 mask, 0x38 strap, 0x3C owner. Writes to the enable, output, direction, level, mask and owner registers read back unchanged in bits 23:0.
- R3: pin_oe[i] is 1 exactly when both the enable bit and the direction bit of pin i are 1. pin_out[i] equals the output bit when pin_oe[i] is 1, and is 0 otherwise.
- R4: The input register shows pin_in after two clock edges and still shows the old value after one edge.
- R5: While the synchronised pin equals its level bit (1 means high, 0 means low), the pin's flag is set on every clock, whether or not the pin is masked.
- R6: Writing a 1 to a flag bit clears it on the next edge. When the level matches in the same cycle, setting wins over clearing.
- R7: irq_main is 1 exactly when some pin has its mask bit and flag bit set and its owner bit clear.
- R8: irq_sub is 1 exactly when some pin has its mask bit, flag bit and owner bit all set.
- R9: The secondary window decodes these byte offsets: 0x00 output, 0x04 direction, 0x08 input, 0x0C level, 0x10 flag, 0x14 mask, 0x18 strap. Its reads return 0 in every bit whose owner bit is 0.
- R10: Writes through the secondary window change only owned bits. This covers flag clears.
- R11: Setting an owner bit makes the pin's existing level, mask and flag state readable at once through the secondary window.
- R12: The strap register captures the synchronised pins on the third clock edge after reset is released, and never changes after that. Writes to it are ignored.
- R13: Bits 31:24 read 0 in every register. Writes to the input register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte address of a 32-bit word; bits 1:0 are ignored |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pin_in | input | 24 | Asynchronous pin levels |
| pin_out | output | 24 | Driven pin values |
| pin_oe | output | 24 | Per-pin drive enable |
| irq_main | output | 1 | Interrupt for pins held by the privileged side |
| irq_sub | output | 1 | Interrupt for pins handed to the secondary side |

## Verification
The assertions assume three things: reset is held across at least one clock edge, the bus address is stable around the edge that takes a write, and pin_in changes no more often than the synchroniser can follow. The bench meets these conditions. It changes pins and bus signals only on falling edges. It holds the pin pattern for three edges before it reads any flag or input value. It keeps the pins fixed from reset until well after the strap capture. For each flag scenario, the bench first moves the level register to a value that cannot match the pins, so that it knows exactly which flags a clear will leave behind.

// File: rtl/gpio_dual_view.sv
module gpio_dual_view #(
  parameter int NPINS = 24,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq_main,
  output logic             irq_sub
);

  localparam int IW = AW - 2;
  localparam logic [IW-1:0] S_OUT = IW'(0),  S_DIR = IW'(1),  S_IN  = IW'(2),
                            S_LVL = IW'(3),  S_FLG = IW'(4),  S_MSK = IW'(5),
                            S_STR = IW'(6),  P_EN  = IW'(7),  P_OUT = IW'(8),
                            P_DIR = IW'(9),  P_IN  = IW'(10), P_LVL = IW'(11),
                            P_FLG = IW'(12), P_MSK = IW'(13), P_STR = IW'(14),
                            P_OWN = IW'(15);

  logic [NPINS-1:0] sync1, in_q, en_q, out_q, dir_q, lvl_q, flg_q, msk_q, own_q, str_q;
  logic [1:0]       boot_q;
  logic             str_done;

  wire [IW-1:0]    idx     = bus_addr[AW-1:2];
  wire             sub_win = (idx <= S_STR);
  wire [NPINS-1:0] vmask   = sub_win ? own_q : '1;
  wire [NPINS-1:0] wbits   = bus_wdata[NPINS-1:0];
  wire [NPINS-1:0] match   = ~(in_q ^ lvl_q);
  wire             unused_ok = &{1'b0, bus_addr[1:0], bus_wdata[31:NPINS]};

  wire wr_en  = bus_we && (idx == P_EN);
  wire wr_out = bus_we && (idx == P_OUT || idx == S_OUT);
  wire wr_dir = bus_we && (idx == P_DIR || idx == S_DIR);
  wire wr_lvl = bus_we && (idx == P_LVL || idx == S_LVL);
  wire wr_flg = bus_we && (idx == P_FLG || idx == S_FLG);
  wire wr_msk = bus_we && (idx == P_MSK || idx == S_MSK);
  wire wr_own = bus_we && (idx == P_OWN);

  function automatic logic [NPINS-1:0] merge(input logic [NPINS-1:0] old,
                                             input logic [NPINS-1:0] nw,
                                             input logic [NPINS-1:0] m);
    return (old & ~m) | (nw & m);
  endfunction

  assign str_done = (boot_q == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      in_q   <= '0;
      boot_q <= '0;
      str_q  <= '0;
    end else begin
      sync1 <= pin_in;
      in_q  <= sync1;
      if (!str_done) boot_q <= boot_q + 2'd1;
      if (boot_q == 2'd2) str_q <= in_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      out_q <= '0;
      dir_q <= '0;
      lvl_q <= '0;
      msk_q <= '0;
      own_q <= '0;
      flg_q <= '0;
    end else begin
      if (wr_en)  en_q  <= wbits;
      if (wr_own) own_q <= wbits;
      if (wr_out) out_q <= merge(out_q, wbits, vmask);
      if (wr_dir) dir_q <= merge(dir_q, wbits, vmask);
      if (wr_lvl) lvl_q <= merge(lvl_q, wbits, vmask);
      if (wr_msk) msk_q <= merge(msk_q, wbits, vmask);
      flg_q <= (flg_q & ~(wr_flg ? (wbits & vmask) : '0)) | match;
    end
  end

  logic [NPINS-1:0] rsel;
  always_comb begin
    case (idx)
      S_OUT, P_OUT: rsel = out_q;
      S_DIR, P_DIR: rsel = dir_q;
      S_IN,  P_IN:  rsel = in_q;
      S_LVL, P_LVL: rsel = lvl_q;
      S_FLG, P_FLG: rsel = flg_q;
      S_MSK, P_MSK: rsel = msk_q;
      S_STR, P_STR: rsel = str_q;
      P_EN:         rsel = en_q;
      P_OWN:        rsel = own_q;
      default:      rsel = '0;
    endcase
  end

  assign bus_rdata = 32'(rsel & vmask);
  assign pin_oe    = en_q & dir_q;
  assign pin_out   = out_q & pin_oe;
  assign irq_main  = |(msk_q & flg_q & ~own_q);
  assign irq_sub   = |(msk_q & flg_q & own_q);

endmodule

module gpio_dual_view_chk #(
  parameter int NPINS = 24,
  parameter int AW    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_we,
  input logic [NPINS-1:0] wdat,
  input logic [NPINS-1:0] in_q,
  input logic [NPINS-1:0] lvl_q,
  input logic [NPINS-1:0] flg_q,
  input logic [NPINS-1:0] out_q,
  input logic [NPINS-1:0] own_q,
  input logic [NPINS-1:0] str_q,
  input logic             str_done,
  input logic             irq_main,
  input logic             irq_sub
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0; else armed <= 1'b1;

  wire [AW-3:0]    idx = bus_addr[AW-1:2];
  wire [NPINS-1:0] m   = ~(in_q ^ lvl_q);

  a_r5_flag_follows_level: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> ((flg_q & $past(m)) == $past(m)));

  a_r6_clear_unmatched: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && bus_we && idx == (AW-2)'(12)) |=> ((flg_q & $past(wdat & ~m)) == '0));

  a_r10_sub_write_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && bus_we && idx == '0) |=> (((out_q ^ $past(out_q)) & ~$past(own_q)) == '0));

  a_r12_straps_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && str_done && $past(str_done)) |-> $stable(str_q));

  a_r7_main_needs_unowned: assert property (@(posedge clk) disable iff (!rst_n)
    irq_main |-> (own_q != '1));

  a_r8_sub_needs_owned: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sub |-> (own_q != '0));
endmodule

bind gpio_dual_view gpio_dual_view_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .wdat(bus_wdata[NPINS-1:0]), .in_q(in_q), .lvl_q(lvl_q), .flg_q(flg_q),
  .out_q(out_q), .own_q(own_q), .str_q(str_q), .str_done(str_done),
  .irq_main(irq_main), .irq_sub(irq_sub));

// File: tb/gpio_dual_view_tb.sv
module gpio_dual_view_tb;
  localparam logic [5:0] S_OUT = 6'h00, S_DIR = 6'h04, S_LVL = 6'h0C,
                         S_FLG = 6'h10, S_MSK = 6'h14, S_STR = 6'h18,
                         P_EN = 6'h1C, P_OUT = 6'h20, P_DIR = 6'h24, P_IN = 6'h28,
                         P_LVL = 6'h2C, P_FLG = 6'h30, P_MSK = 6'h34, P_STR = 6'h38,
                         P_OWN = 6'h3C;
  localparam logic [23:0] STRAP = 24'h5A3C96;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [23:0] pin_in = STRAP, pin_out, pin_oe;
  logic irq_main, irq_sub;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  gpio_dual_view u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_main(irq_main), .irq_sub(irq_sub));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 0;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [23:0] mix(input int s);
    logic [31:0] h = 32'(s) * 32'h9E3779B1 + 32'h7F4A7C15;
    return h[27:4] ^ h[31:8];
  endfunction

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [23:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R1 reset values
    rd(P_EN, v);  chk("R1 enable", v, 0);
    rd(P_OUT, v); chk("R1 out", v, 0);
    rd(P_DIR, v); chk("R1 dir", v, 0);
    rd(P_LVL, v); chk("R1 level", v, 0);
    rd(P_MSK, v); chk("R1 mask", v, 0);
    rd(P_OWN, v); chk("R1 owner", v, 0);
    chk("R1 pin_oe", 32'(pin_oe), 0);

    // R12 strap capture and hold
    rd(P_STR, v); chk("R12 strap", v, 32'(STRAP));
    rd(S_STR, v); chk("R9 sub strap unowned", v, 0);
    pin_in = 24'h000000; settle();
    wr(P_STR, 32'hFFFFFFFF);
    rd(P_STR, v); chk("R12 strap held", v, 32'(STRAP));

    // R2 R3 drive sweep
    for (int i = 0; i < 16; i++) begin
      logic [23:0] e, d, o;
      e = mix(i); d = mix(i + 40); o = mix(i + 80);
      wr(P_EN, 32'(e)); wr(P_DIR, 32'(d)); wr(P_OUT, 32'(o));
      chk("R3 pin_oe", 32'(pin_oe), 32'(e & d));
      chk("R3 pin_out", 32'(pin_out), 32'(o & e & d));
      rd(P_EN, v);  chk("R2 enable rb", v, 32'(e));
      rd(P_DIR, v); chk("R2 dir rb", v, 32'(d));
      rd(P_OUT, v); chk("R2 out rb", v, 32'(o));
    end

    // R4 synchroniser latency, walking ones
    prev = 24'h000000;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); pin_in = 24'h1 << i;
      @(negedge clk); rd(P_IN, v); chk("R4 one edge", v, 32'(prev));
      @(negedge clk); rd(P_IN, v); chk("R4 two edges", v, 32'(24'h1 << i));
      prev = 24'h1 << i;
    end

    // R5 R6 R7 R8 R9 R10 R11 flag and interrupt sweep
    for (int i = 0; i < 12; i++) begin
      logic [23:0] p, l, mk, o, m;
      p = mix(i + 200); l = mix(i + 300); mk = mix(i + 400); o = mix(i + 500);
      m = ~(p ^ l);
      wr(P_OWN, 0); wr(P_MSK, 0);
      pin_in = p; settle();
      wr(P_LVL, 32'(l)); @(negedge clk);
      wr(P_FLG, 32'hFFFFFF);
      rd(P_FLG, v); chk("R6 set beats clear", v, 32'(m));
      wr(P_LVL, 32'(~p)); @(negedge clk);
      wr(P_FLG, 32'hFFFFFF);
      rd(P_FLG, v); chk("R6 clear", v, 0);
      wr(P_LVL, 32'(l)); @(negedge clk);
      rd(P_FLG, v); chk("R5 flag unmasked", v, 32'(m));
      chk("R7 irq_main no mask", 32'(irq_main), 0);
      wr(P_MSK, 32'(mk));
      chk("R7 irq_main", 32'(irq_main), 32'(|(mk & m)));
      chk("R8 irq_sub none owned", 32'(irq_sub), 0);
      wr(P_OWN, 32'(o));
      chk("R7 irq_main split", 32'(irq_main), 32'(|(mk & m & ~o)));
      chk("R8 irq_sub split", 32'(irq_sub), 32'(|(mk & m & o)));
      rd(S_FLG, v); chk("R11 sub flag view", v, 32'(m & o));
      rd(S_MSK, v); chk("R11 sub mask view", v, 32'(mk & o));
      rd(S_LVL, v); chk("R9 sub level view", v, 32'(l & o));
      wr(P_LVL, 32'(~p)); @(negedge clk);
      wr(S_FLG, 32'hFFFFFFFF);
      rd(P_FLG, v); chk("R10 sub clear owned only", v, 32'(m & ~o));
      wr(P_FLG, 32'hFFFFFF);
    end

    // R10 R9 R12 R13 secondary write masking
    for (int i = 0; i < 12; i++) begin
      logic [23:0] x, o, w;
      x = mix(i + 600); o = mix(i + 700); w = mix(i + 800);
      wr(P_OWN, 32'(o)); wr(P_OUT, 32'(x)); wr(P_DIR, 32'(x ^ 24'hFFFFFF));
      rd(S_OUT, v); chk("R9 sub out view", v, 32'(x & o));
      wr(S_OUT, 32'(w));
      rd(P_OUT, v); chk("R10 sub out write", v, 32'((x & ~o) | (w & o)));
      wr(S_DIR, 32'(w));
      rd(P_DIR, v); chk("R10 sub dir write", v, 32'(((x ^ 24'hFFFFFF) & ~o) | (w & o)));
      rd(S_STR, v); chk("R12 sub strap view", v, 32'(STRAP & o));
    end
    wr(P_OUT, 32'hFFFFFFFF);
    rd(P_OUT, v); chk("R13 upper bits", v, 32'h00FFFFFF);
    pin_in = 24'h0F0F0F; settle();
    wr(P_IN, 32'hFFFFFFFF);
    rd(P_IN, v); chk("R13 input read-only", v, 32'h000F0F0F);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule